// File: doc/BRIEF.md
# Two-Channel HDLC Framing Multiplexer

This block merges two byte streams onto one fixed-rate bit-serial link. Each stream offers bytes through a valid/ready handshake. The downstream link pulls one bit per pulse of its bit enable, and the block always has a bit ready for that pulse.

When a byte is waiting, the block wraps it in an HDLC frame. The frame carries an address byte naming the source stream and a CRC-16 check sequence. Zero-bit stuffing is applied, so the flag pattern cannot appear inside a frame. When neither stream has data, the link carries back-to-back flags.

Stream 1 wins whenever both streams are waiting at a frame boundary. A frame stays with one stream until that stream runs dry or the information field reaches its length limit.

Top module: `hdlcmux_tx`

## Requirements
- R1: While reset is held, and after reset until the first bit enable, `ser_out` is 0 and both ready outputs are 0. The first eight bits sent after reset form the flag 0x7E.
- R2: `ser_out` changes only at a clock edge where `bit_en` is 1, and each such edge presents exactly one new bit. `ser_out` holds its value while `bit_en` is 0.
- R3: A frame is sent in this order: an opening flag 0x7E, one address byte, zero or more whole information bytes, two check bytes, and a closing flag 0x7E. Every byte is sent most significant bit first.
- R4: The address byte is 0x01 for frames carrying stream 1 bytes and 0x02 for frames carrying stream 2 bytes.
- R5: The stream is chosen only at the end of an opening flag. If stream 1 has a valid byte, stream 1 is chosen; otherwise stream 2 is chosen if it has one. Stream bytes leave in the order they were accepted.
- R6: A frame ends when its stream has no valid byte at the moment the next information byte is due, or when `MAX_INFO` information bytes have been sent. `MAX_INFO` defaults to 1024.
- R7: The check sequence is computed with polynomial 0x1021, a register preset to 0xFFFF, and MSB-first processing over the address and information bits. The result is complemented and sent high byte first.
- R8: After five consecutive 1 bits in the address, information or check fields, a 0 bit is inserted. This includes the case where the five 1s end the last check byte. The inserted bit takes one bit-enable slot. Flag bits are never stuffed, and they clear the run of 1s.
- R9: When no stream has a valid byte at a frame decision point, another 0x7E flag follows, so an idle link carries a continuous flag sequence.
- R10: A byte is accepted on a clock edge where its stream's valid and ready are both 1. Ready is raised only in a bit-enable slot where the next information byte of that stream's current frame is due, and never for both streams at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s1_data | input | 8 | Stream 1 byte |
| s1_valid | input | 1 | Stream 1 byte present |
| s1_ready | output | 1 | Stream 1 byte taken at this edge when valid |
| s2_data | input | 8 | Stream 2 byte |
| s2_valid | input | 1 | Stream 2 byte present |
| s2_ready | output | 1 | Stream 2 byte taken at this edge when valid |
| bit_en | input | 1 | Link bit slot: advance the serial output by one bit |
| ser_out | output | 1 | Serial link bit |

## Verification
Two functions can fall due in the same bit slot. In the first case, a stuffed zero becomes due in the slot where the next byte would be fetched or the check bytes would be loaded. The bench provokes this with payload bytes such as 0xFF, 0x1F and 0xFC, including runs that span byte edges, and it repeats the pattern with a gapped bit enable. In the second case, the frame decision meets both streams valid at once, including at the restart after a full 1024-byte frame. The bench judges both cases with an independent serial decoder that removes stuffing, finds flags and recomputes the CRC byte by byte. It then compares each frame's address order and length, and its payload against per-stream scoreboard queues.

// File: rtl/hdlcmux_pkg.sv
package hdlcmux_pkg;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [2:0]  RUN_LIMIT  = 3'd5;

  typedef enum logic [2:0] {
    PH_OPEN, PH_ADDR, PH_INFO, PH_FCS_HI, PH_FCS_LO, PH_CLOSE
  } phase_t;

  typedef enum logic {SEL_S1 = 1'b0, SEL_S2 = 1'b1} sel_t;

  // one MSB-first CRC step
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  function automatic logic [7:0] addr_of(input sel_t s);
    return (s == SEL_S1) ? 8'h01 : 8'h02;
  endfunction

  function automatic logic [2:0] run_next(input logic [2:0] run, input logic b);
    return b ? run + 3'd1 : 3'd0;
  endfunction
endpackage

// File: rtl/hdlcmux_arb.sv
module hdlcmux_arb
  import hdlcmux_pkg::*;
(
  input  logic s1_valid,
  input  logic s2_valid,
  output logic any_pending,
  output sel_t pick
);
  always_comb begin
    any_pending = s1_valid | s2_valid;
    pick        = s1_valid ? SEL_S1 : SEL_S2;
  end
endmodule

// File: rtl/hdlcmux_fcs.sv
module hdlcmux_fcs
  import hdlcmux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        step,
  input  logic        din,
  output logic [15:0] crc_nxt
);
  logic [15:0] crc_q;

  always_comb crc_nxt = step ? crc_step(crc_q, din) : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_PRESET;
    else if (clear) crc_q <= CRC_PRESET;
    else if (step)  crc_q <= crc_nxt;
  end
endmodule

// File: rtl/hdlcmux_stuff.sv
module hdlcmux_stuff
  import hdlcmux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       bit_val,
  input  logic       is_flag,
  output logic       stuff_now,
  output logic [2:0] run_cnt
);
  always_comb stuff_now = (run_cnt == RUN_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= 3'd0;
    else if (adv) begin
      if (stuff_now || is_flag) run_cnt <= 3'd0;
      else                      run_cnt <= run_next(run_cnt, bit_val);
    end
  end
endmodule

// File: rtl/hdlcmux_tx.sv
module hdlcmux_tx
  import hdlcmux_pkg::*;
#(
  parameter int MAX_INFO = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s1_data,
  input  logic       s1_valid,
  output logic       s1_ready,
  input  logic [7:0] s2_data,
  input  logic       s2_valid,
  output logic       s2_ready,
  input  logic       bit_en,
  output logic       ser_out
);
  localparam int IW = $clog2(MAX_INFO + 1);

  phase_t        ph;
  sel_t          cur;
  logic [7:0]    sh;
  logic [2:0]    bcnt;
  logic [IW-1:0] info_cnt;
  logic [7:0]    fcs_lo;
  logic          ser_q;

  // named internal events
  logic        stuff_now;
  logic [2:0]  run_cnt;
  logic        emit, byte_end, in_flag, crc_field;
  logic        want_info, take, frame_start, any_pending;
  sel_t        start_sel;
  logic        cur_valid;
  logic [7:0]  cur_data;
  logic [15:0] crc_nxt;

  hdlcmux_arb u_arb (
    .s1_valid(s1_valid), .s2_valid(s2_valid),
    .any_pending(any_pending), .pick(start_sel)
  );

  always_comb begin
    emit        = bit_en && !stuff_now;
    byte_end    = emit && (bcnt == 3'd7);
    in_flag     = (ph == PH_OPEN) || (ph == PH_CLOSE);
    crc_field   = (ph == PH_ADDR) || (ph == PH_INFO);
    want_info   = byte_end && crc_field && (info_cnt < IW'(MAX_INFO));
    cur_valid   = (cur == SEL_S1) ? s1_valid : s2_valid;
    cur_data    = (cur == SEL_S1) ? s1_data : s2_data;
    take        = want_info && cur_valid;
    frame_start = byte_end && (ph == PH_OPEN) && any_pending;
    s1_ready    = want_info && (cur == SEL_S1);
    s2_ready    = want_info && (cur == SEL_S2);
  end

  hdlcmux_fcs u_fcs (
    .clk(clk), .rst_n(rst_n), .clear(frame_start),
    .step(emit && crc_field), .din(sh[7]), .crc_nxt(crc_nxt)
  );

  hdlcmux_stuff u_stuff (
    .clk(clk), .rst_n(rst_n), .adv(bit_en), .bit_val(sh[7]),
    .is_flag(in_flag), .stuff_now(stuff_now), .run_cnt(run_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_OPEN;
      cur      <= SEL_S1;
      sh       <= FLAG_BYTE;
      bcnt     <= 3'd0;
      info_cnt <= '0;
      fcs_lo   <= 8'h00;
      ser_q    <= 1'b0;
    end else begin
      if (bit_en) ser_q <= stuff_now ? 1'b0 : sh[7];
      if (emit) bcnt <= bcnt + 3'd1;
      if (emit && !byte_end) sh <= {sh[6:0], 1'b0};
      if (byte_end) begin
        unique case (ph)
          PH_OPEN: begin
            if (any_pending) begin
              ph       <= PH_ADDR;
              cur      <= start_sel;
              sh       <= addr_of(start_sel);
              info_cnt <= '0;
            end else begin
              sh <= FLAG_BYTE;
            end
          end
          PH_ADDR, PH_INFO: begin
            if (take) begin
              ph       <= PH_INFO;
              sh       <= cur_data;
              info_cnt <= info_cnt + 1'b1;
            end else begin
              ph     <= PH_FCS_HI;
              sh     <= ~crc_nxt[15:8];
              fcs_lo <= ~crc_nxt[7:0];
            end
          end
          PH_FCS_HI: begin
            ph <= PH_FCS_LO;
            sh <= fcs_lo;
          end
          PH_FCS_LO: begin
            ph <= PH_CLOSE;
            sh <= FLAG_BYTE;
          end
          default: begin
            ph <= PH_OPEN;
            sh <= FLAG_BYTE;
          end
        endcase
      end
    end
  end

  assign ser_out = ser_q;
endmodule

// File: rtl/hdlcmux_chk.sv
module hdlcmux_chk
  import hdlcmux_pkg::*;
#(
  parameter int MAX_INFO = 1024,
  parameter int IW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          ser_out,
  input logic          s1_valid,
  input logic          s1_ready,
  input logic          s2_ready,
  input logic          stuff_now,
  input logic [2:0]    run_cnt,
  input logic          frame_start,
  input sel_t          start_sel,
  input logic [IW-1:0] info_cnt
);
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));

  assert_single_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s1_ready, s2_ready}));

  assert_ready_in_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_ready || s2_ready) |-> bit_en);

  assert_stuff_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now) |=> !ser_out);

  assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_LIMIT);

  assert_info_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    info_cnt <= IW'(MAX_INFO));

  assert_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && s1_valid) |-> (start_sel == SEL_S1));
endmodule

bind hdlcmux_tx hdlcmux_chk #(.MAX_INFO(MAX_INFO), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_out(ser_out),
  .s1_valid(s1_valid), .s1_ready(s1_ready), .s2_ready(s2_ready),
  .stuff_now(stuff_now), .run_cnt(run_cnt), .frame_start(frame_start),
  .start_sel(start_sel), .info_cnt(info_cnt)
);

// File: tb/test_hdlcmux_tx.sv
module test_hdlcmux_tx;
  localparam int MAXI = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] s1_data = 8'h00, s2_data = 8'h00;
  logic s1_valid = 1'b0, s2_valid = 1'b0, bit_en = 1'b0;
  logic s1_ready, s2_ready, ser_out;

  always #2 clk = ~clk;

  hdlcmux_tx #(.MAX_INFO(MAXI)) i_hdlcmux_tx (
    .clk(clk), .rst_n(rst_n), .s1_data(s1_data), .s1_valid(s1_valid),
    .s1_ready(s1_ready), .s2_data(s2_data), .s2_valid(s2_valid),
    .s2_ready(s2_ready), .bit_en(bit_en), .ser_out(ser_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q1[$], q2[$], exp1[$], exp2[$];
  logic [7:0] addr_log[$];
  int len_log[$];
  bit run = 0;
  int gap = 1;
  int cyc = 0;
  bit fire1 = 0, fire2 = 0, en_d = 0;
  logic last_ser = 1'b0;
  int r2_viol = 0;
  // decoder state
  bit synced = 0;
  int ones = 0;
  bit fb[$];
  int idle_flags = 0, aborts = 0, raw_cnt = 0;
  logic [7:0] first_byte = 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] b[$], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {b[i], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic take_frame(input int n);
    logic [7:0] by[$];
    logic [15:0] c, got;
    int plen;
    bit match;
    logic [7:0] e;
    chk((n % 8 == 0) && (n >= 24), "R3 frame bit count", n, 24);
    if ((n % 8 != 0) || (n < 24)) return;
    for (int i = 0; i < n / 8; i++) begin
      logic [7:0] v = 8'h00;
      for (int k = 0; k < 8; k++) v = {v[6:0], fb[i*8+k]};
      by.push_back(v);
    end
    plen = by.size() - 3;
    chk(by[0] == 8'h01 || by[0] == 8'h02, "R4 address", by[0], 8'h01);
    chk(plen <= MAXI, "R6 info length", plen, MAXI);
    c = ~ref_crc(by, plen + 1);
    got = {by[plen+1], by[plen+2]};
    chk(got == c, "R7 check sequence", got, c);
    match = 1;
    for (int i = 1; i <= plen; i++) begin
      if (by[0] == 8'h01) e = (exp1.size() > 0) ? exp1.pop_front() : 8'hxx;
      else e = (exp2.size() > 0) ? exp2.pop_front() : 8'hxx;
      if (e !== by[i]) match = 0;
    end
    chk(match, "R5 R10 payload order", match, 1);
    addr_log.push_back(by[0]);
    len_log.push_back(plen);
  endtask

  task automatic rx_bit(input logic b);
    if (raw_cnt < 8) first_byte = {first_byte[6:0], b};
    raw_cnt++;
    if (b) begin
      ones++;
      fb.push_back(1'b1);
      if (ones > 6) begin
        aborts++;
        ones = 0;
      end
    end else begin
      if (ones == 6) begin
        if (synced) begin
          if (fb.size() - 7 > 0) take_frame(fb.size() - 7);
          else idle_flags++;
        end
        synced = 1;
        fb.delete();
      end else if (ones != 5) begin
        fb.push_back(1'b0);
      end
      ones = 0;
    end
  endtask

  // single driver / monitor process at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (en_d) rx_bit(ser_out);
      else if (ser_out !== last_ser) r2_viol++;
      last_ser = ser_out;
      if (fire1) void'(q1.pop_front());
      if (fire2) void'(q2.pop_front());
      cyc++;
      bit_en   = run && (cyc % gap == 0);
      s1_valid = run && (q1.size() > 0);
      s1_data  = (q1.size() > 0) ? q1[0] : 8'h00;
      s2_valid = run && (q2.size() > 0);
      s2_data  = (q2.size() > 0) ? q2[0] : 8'h00;
      #1;
      fire1 = s1_valid && s1_ready;
      fire2 = s2_valid && s2_ready;
      en_d  = bit_en;
    end
  end

  task automatic push(input int s, input logic [7:0] v);
    if (s == 1) begin q1.push_back(v); exp1.push_back(v); end
    else begin q2.push_back(v); exp2.push_back(v); end
  endtask

  task automatic drain();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (q1.size() == 0 && q2.size() == 0 && exp1.size() == 0 && exp2.size() == 0) break;
    end
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    #2;
    chk(ser_out == 1'b0 && !s1_ready && !s2_ready, "R1 reset outputs",
        {ser_out, s1_ready, s2_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(ser_out == 1'b0 && !s1_ready && !s2_ready, "R1 after reset, no slot",
        {ser_out, s1_ready, s2_ready}, 0);

    // idle link
    run = 1;
    repeat (400) @(negedge clk);
    chk(first_byte == 8'h7E, "R1 first byte is flag", first_byte, 8'h7E);
    chk(idle_flags >= 45, "R9 idle flag count", idle_flags, 45);
    chk(addr_log.size() == 0, "R9 no frame while idle", addr_log.size(), 0);

    // stream 1, stuffing-heavy bytes
    base = addr_log.size();
    push(1, 8'h00); push(1, 8'hFF); push(1, 8'h7E); push(1, 8'hFC);
    push(1, 8'h1F); push(1, 8'hFF); push(1, 8'hA5);
    drain();
    chk(addr_log.size() == base + 1, "R3 one frame", addr_log.size(), base + 1);
    chk(addr_log[base] == 8'h01, "R4 stream 1 address", addr_log[base], 8'h01);
    chk(len_log[base] == 7, "R6 length 7", len_log[base], 7);

    // priority with both waiting
    run = 0;
    base = addr_log.size();
    for (int i = 0; i < 4; i++) push(2, 8'(8'hC0 + i));
    for (int i = 0; i < 4; i++) push(1, 8'(8'hF8 + i));
    run = 1;
    drain();
    chk(addr_log.size() == base + 2, "R5 two frames", addr_log.size(), base + 2);
    chk(addr_log[base] == 8'h01 && addr_log[base+1] == 8'h02, "R5 stream 1 first",
        {addr_log[base], addr_log[base+1]}, 16'h0102);

    // gapped bit enable
    gap = 3;
    base = addr_log.size();
    push(2, 8'hFF); push(2, 8'hFF); push(2, 8'h3E); push(2, 8'hF1);
    push(2, 8'h1F); push(2, 8'h80); push(2, 8'hFF); push(2, 8'h0F);
    drain();
    chk(addr_log.size() == base + 1 && addr_log[base] == 8'h02, "R2 R4 gapped frame",
        addr_log[base], 8'h02);
    chk(r2_viol == 0, "R2 output held between slots", r2_viol, 0);
    gap = 1;

    // length limit on stream 2
    base = addr_log.size();
    for (int i = 0; i < 1030; i++) push(2, 8'(i * 7 + 3));
    drain();
    chk(addr_log.size() == base + 2, "R6 split count", addr_log.size(), base + 2);
    chk(len_log[base] == MAXI && len_log[base+1] == 6, "R6 split lengths",
        len_log[base], MAXI);

    // limit plus reselection with both streams
    run = 0;
    base = addr_log.size();
    for (int i = 0; i < 1030; i++) push(1, 8'(i * 13 + 1));
    push(2, 8'h55); push(2, 8'hFE); push(2, 8'h7F);
    run = 1;
    drain();
    chk(addr_log.size() == base + 3, "R5 R6 frame count", addr_log.size(), base + 3);
    chk(addr_log[base] == 8'h01 && addr_log[base+1] == 8'h01 && addr_log[base+2] == 8'h02,
        "R5 order after limit", {addr_log[base], addr_log[base+1], addr_log[base+2]}, 24'h010102);
    chk(len_log[base] == MAXI && len_log[base+1] == 6 && len_log[base+2] == 3,
        "R6 lengths after limit", len_log[base+1], 6);

    // source runs dry between bursts
    base = addr_log.size();
    push(1, 8'h11); push(1, 8'h22); push(1, 8'h33);
    drain();
    push(1, 8'h44); push(1, 8'h55);
    drain();
    chk(addr_log.size() == base + 2 && len_log[base] == 3 && len_log[base+1] == 2,
        "R6 close on empty source", addr_log.size(), base + 2);

    chk(aborts == 0, "R8 no run of seven ones", aborts, 0);
    chk(exp1.size() == 0 && exp2.size() == 0, "R10 all bytes delivered",
        exp1.size() + exp2.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule